// File: doc/BRIEF.md
# 16-bit Adder-Subtractor with Status Flags

This block is a purely combinational arithmetic unit. It takes a destination operand, a source operand and a one-bit operation select. It returns a 16-bit result together with four status bits: carry, overflow, zero and sign. Addition and subtraction share a single ripple adder. For subtraction the source is passed through a selectable inverter and the adder's carry-in is forced high, so the adder forms dst + ~src + 1.

The carry produced by a subtraction is the adder's carry-out as it stands. It is never turned into a borrow. As a result, carry is set whenever dst is at least src as unsigned values, and 0 minus 0 sets it. The adder treats its operands the same way whether they are read as signed or unsigned. Only the overflow bit assumes a two's-complement reading, and it is judged against the sign of the destination operand. The block has no clock or state, so the outputs follow the inputs within the same cycle.

Top module: `aso_addsub`

## Requirements
- R1: With op_sub_i = 0 (add), res_o equals (dst_i + src_i) modulo 2^16.
- R2: With op_sub_i = 1 (subtract), res_o equals (dst_i - src_i) modulo 2^16, formed as dst_i + ~src_i + 1.
- R3: For an add, carry_o is the carry out of bit 15, so it is set exactly when dst_i + src_i exceeds 0xFFFF.
- R4: For a subtract, carry_o is the raw adder carry-out with no inversion. It is set exactly when dst_i >= src_i as unsigned values, so 0x0000 - 0x0000 gives carry_o = 1.
- R5: For an add, ovf_o is set when dst_i[15] equals src_i[15] and res_o[15] differs from dst_i[15]. Examples: 0x7777 + 0x7777 gives 0xEEEE with overflow set and carry clear; 0x9999 + 0x7777 gives 0x1110 with carry set and overflow clear.
- R6: For a subtract, ovf_o is set when dst_i[15] differs from src_i[15] and res_o[15] differs from dst_i[15].
- R7: zero_o is set exactly when res_o is 0x0000.
- R8: sign_o equals res_o[15].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 16 | Destination operand (minuend for subtract) |
| src_i | input | 16 | Source operand (subtrahend for subtract) |
| op_sub_i | input | 1 | 0 selects add, 1 selects subtract |
| res_o | output | 16 | Arithmetic result |
| carry_o | output | 1 | Adder carry-out of bit 15 |
| ovf_o | output | 1 | Two's-complement overflow |
| zero_o | output | 1 | Result is all zeros |
| sign_o | output | 1 | Most significant bit of result |

## Verification
The table holds operand pairs chosen to separate the two flags. Each pair checks that carry and overflow are set and cleared independently: positive plus positive with no carry but with overflow, and mixed signs with carry but no overflow. The subtract entries cover equal operands, where a raw carry differs from a borrow, and the extremes 0x8000 and 0x7FFF. They also include subtracting 0x8000 from zero, which catches an overflow rule taken from the source rather than the destination. A pseudo-random sweep over both operations then compares every output against an unsigned 17-bit reference. That sweep exposes broken carry chains at any bit position.

// File: rtl/aso_pkg.sv
package aso_pkg;
    localparam int unsigned ASO_W = 16;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } aso_op_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
        logic sign;
    } aso_flags_t;
endpackage

// File: rtl/aso_opnd_cond.sv
module aso_opnd_cond #(
    parameter int unsigned W = 16
) (
    input  aso_pkg::aso_op_e op,
    input  logic [W-1:0]     src,
    output logic [W-1:0]     b_out,
    output logic             cin
);
    always_comb begin
        unique case (op)
            aso_pkg::OP_ADD: begin
                b_out = src;
                cin   = 1'b0;
            end
            aso_pkg::OP_SUB: begin
                b_out = ~src;
                cin   = 1'b1;
            end
            default: begin
                b_out = src;
                cin   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/aso_ripple.sv
module aso_ripple #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_into_msb,
    output logic         cout
);
    logic [W:0] chain;
    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_fa
        logic p;
        assign p          = a[i] ^ b[i];
        assign sum[i]     = p ^ chain[i];
        assign chain[i+1] = (a[i] & b[i]) | (p & chain[i]);
    end

    assign c_into_msb = chain[W-1];
    assign cout       = chain[W];
endmodule

// File: rtl/aso_flags.sv
module aso_flags #(
    parameter int unsigned W = 16
) (
    input  aso_pkg::aso_op_e    op,
    input  logic [W-1:0]        res,
    input  logic                dst_msb,
    input  logic                src_msb,
    input  logic                cout,
    output aso_pkg::aso_flags_t flags
);
    logic same_sign;
    logic res_flip;

    assign same_sign = (dst_msb == src_msb);
    assign res_flip  = (res[W-1] != dst_msb);

    always_comb begin
        flags.carry = cout;
        flags.zero  = (res == '0);
        flags.sign  = res[W-1];
        unique case (op)
            aso_pkg::OP_ADD: flags.ovf = same_sign & res_flip;
            aso_pkg::OP_SUB: flags.ovf = ~same_sign & res_flip;
            default:         flags.ovf = 1'b0;
        endcase
    end

    always_comb begin
        if (!$isunknown({res, flags})) begin
            // R7 R8
            zero_sign_chk: assert (!(flags.zero && flags.sign))
                else $error("zero and sign both set");
        end
    end
endmodule

// File: rtl/aso_addsub.sv
module aso_addsub #(
    parameter int unsigned W = aso_pkg::ASO_W
) (
    input  logic [W-1:0] dst_i,
    input  logic [W-1:0] src_i,
    input  logic         op_sub_i,
    output logic [W-1:0] res_o,
    output logic         carry_o,
    output logic         ovf_o,
    output logic         zero_o,
    output logic         sign_o
);
    import aso_pkg::*;

    aso_op_e     op;
    logic [W-1:0] b_sel;
    logic         cin;
    logic [W-1:0] sum;
    logic         c_msb;
    logic         cout;
    aso_flags_t   flg;

    assign op = op_sub_i ? OP_SUB : OP_ADD;

    aso_opnd_cond #(.W(W)) u_cond (
        .op   (op),
        .src  (src_i),
        .b_out(b_sel),
        .cin  (cin)
    );

    aso_ripple #(.W(W)) u_add (
        .a         (dst_i),
        .b         (b_sel),
        .cin       (cin),
        .sum       (sum),
        .c_into_msb(c_msb),
        .cout      (cout)
    );

    aso_flags #(.W(W)) u_flags (
        .op     (op),
        .res    (sum),
        .dst_msb(dst_i[W-1]),
        .src_msb(src_i[W-1]),
        .cout   (cout),
        .flags  (flg)
    );

    assign res_o   = sum;
    assign carry_o = flg.carry;
    assign ovf_o   = flg.ovf;
    assign zero_o  = flg.zero;
    assign sign_o  = flg.sign;

    always_comb begin
        if (!$isunknown({dst_i, src_i, op_sub_i, res_o, carry_o, ovf_o, c_msb, cout})) begin
            // R5 R6
            ovf_chain_chk: assert (ovf_o == (c_msb ^ cout))
                else $error("overflow disagrees with carry chain");
            // R1 R3
            add_sum_chk: assert (op_sub_i || ({carry_o, res_o} == ({1'b0, dst_i} + {1'b0, src_i})))
                else $error("add result or carry wrong");
            // R4
            sub_carry_chk: assert (!op_sub_i || (carry_o == (dst_i >= src_i)))
                else $error("subtract carry is not raw carry-out");
            // R2 R7
            sub_equal_chk: assert (!op_sub_i || (dst_i != src_i) || (zero_o && carry_o))
                else $error("equal operands subtract wrong");
        end
    end
endmodule

// File: tb/sim_aso_addsub.sv
module sim_aso_addsub;
    logic        clk = 1'b0;
    logic [15:0] dst, src;
    logic        op_sub;
    logic [15:0] res;
    logic        carry, ovf, zero, sign;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    always #4 clk = ~clk;

    aso_addsub u0 (
        .dst_i   (dst),
        .src_i   (src),
        .op_sub_i(op_sub),
        .res_o   (res),
        .carry_o (carry),
        .ovf_o   (ovf),
        .zero_o  (zero),
        .sign_o  (sign)
    );

    // {op_sub, dst, src, res, carry, ovf}
    typedef struct packed {
        logic        s;
        logic [15:0] d;
        logic [15:0] a;
        logic [15:0] r;
        logic        c;
        logic        v;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{1'b0, 16'h7777, 16'h7777, 16'hEEEE, 1'b0, 1'b1},
        '{1'b0, 16'h9999, 16'h7777, 16'h1110, 1'b1, 1'b0},
        '{1'b0, 16'h3124, 16'h0008, 16'h312C, 1'b0, 1'b0},
        '{1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b0},
        '{1'b0, 16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b1},
        '{1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0},
        '{1'b1, 16'h0005, 16'h0003, 16'h0002, 1'b1, 1'b0},
        '{1'b1, 16'h0003, 16'h0005, 16'hFFFE, 1'b0, 1'b0},
        '{1'b1, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 1'b1},
        '{1'b1, 16'h7FFF, 16'hFFFF, 16'h8000, 1'b0, 1'b1},
        '{1'b1, 16'h1234, 16'h0000, 16'h1234, 1'b1, 1'b0},
        '{1'b1, 16'h0000, 16'h8000, 16'h8000, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: dst=%h src=%h sub=%b actual=%h expected=%h",
                     req, dst, src, op_sub, act, exp);
        end
    endtask

    task automatic apply_check(input logic s, input logic [15:0] d, input logic [15:0] a);
        logic [16:0] full;
        logic        v;
        dst = d; src = a; op_sub = s;
        @(negedge clk);
        full = s ? ({1'b0, d} + {1'b0, ~a} + 17'd1) : ({1'b0, d} + {1'b0, a});
        if (s) v = (d[15] != a[15]) && (full[15] != d[15]);
        else   v = (d[15] == a[15]) && (full[15] != d[15]);
        chk(s ? "R2" : "R1", res, full[15:0]);
        chk(s ? "R4" : "R3", {15'd0, carry}, {15'd0, full[16]});
        chk(s ? "R6" : "R5", {15'd0, ovf}, {15'd0, v});
        chk("R7", {15'd0, zero}, {15'd0, full[15:0] == 16'd0});
        chk("R8", {15'd0, sign}, {15'd0, full[15]});
    endtask

    initial begin
        logic [15:0] lf;
        dst = '0; src = '0; op_sub = 1'b0;
        @(negedge clk);
        // table walk: fixed expectations for R1..R6
        foreach (VT[i]) begin
            dst = VT[i].d; src = VT[i].a; op_sub = VT[i].s;
            @(negedge clk);
            chk(VT[i].s ? "R2" : "R1", res, VT[i].r);
            chk(VT[i].s ? "R4" : "R3", {15'd0, carry}, {15'd0, VT[i].c});
            chk(VT[i].s ? "R6" : "R5", {15'd0, ovf}, {15'd0, VT[i].v});
            chk("R7", {15'd0, zero}, {15'd0, VT[i].r == 16'd0});
            chk("R8", {15'd0, sign}, {15'd0, VT[i].r[15]});
        end
        // directed corners: R4 raw carry on equal operands, R7 zero
        apply_check(1'b1, 16'hFFFF, 16'hFFFF);
        apply_check(1'b1, 16'h8000, 16'h8000);
        apply_check(1'b0, 16'h0000, 16'h0000);
        apply_check(1'b1, 16'h8000, 16'h7FFF);
        // pseudo-random sweep, both operations
        lf = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            logic [15:0] d0;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            d0 = lf;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            apply_check(k[0], d0, lf ^ {k[7:0], 8'h5A});
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int t = 0; t < 20000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule